// File: doc/BRIEF.md
# Compare-Mode Event Timer Channel

This block is one up-counting timer channel that produces a timer event when its counter steps onto a programmable compare value. Software configures it through a small word-wide register port. It picks a count clock, writes the compare value, and then issues commands to arm, stop or restart the count. Each compare sets a sticky status flag. When the matching mask bit is set, that flag drives a level interrupt.

Two behaviours follow a compare. In periodic operation the counter falls back to zero on the next count clock and keeps going, so an event arrives every compare+1 count clocks. In one-shot operation the channel's count clock is switched off at the compare, and the counter holds the compare value until software restarts it. The count clock is the system clock divided by 2, 8, 32 or 128, or an externally supplied slow tick. The counter width is a parameter, normally 16 or 32 bits.

Top module: `evt_tmr_chan`

## Requirements
- R1: After reset, the mode, compare, mask, status and counter registers all read zero, and `irq` is low.
- R2: Mode bits [2:0] select the count clock. Codes 0, 1, 2 and 3 divide the system clock by 2, 8, 32 and 128. After a restart, the first increment lands exactly one divide period later. Code 4 counts one step per system clock in which `slow_tick` is high. Codes 5 to 7 never count.
- R3: While counting, an increment that makes the counter equal the compare value sets the compare flag. The next count clock returns the counter to zero, which gives a period of compare+1 count clocks.
- R4: With mode bit 3 set (one-shot), a compare also switches the channel clock off. The counter then holds the compare value, and the clock-running status bit reads 0.
- R5: A write to the command register (address 2) acts on bits as follows. Bit 0 arms counting. Bit 1 stops counting and wins over bit 0 when both are written. Bit 2 zeroes the counter and the prescaler. Writing bits 0 and 2 together starts a new timeout. The command register reads as zero.
- R6: The status register (address 3) has two bits. Bit 0 is the compare flag and bit 1 shows whether the channel clock is running. Reading it clears the flag, unless a compare happens in that same cycle.
- R7: `irq` is high exactly when the compare flag and mask bit 0 are both set. Writing a 1 to bit 0 at address 4 sets the mask bit. Writing a 1 to bit 0 at address 5 clears it. Writing 0xFF to address 5 clears the whole mask. The mask reads back at address 6.
- R8: A compare-value write (address 1) takes effect on the next count clock. The flag is never set while the counter is stopped, even when the new value equals the held count.
- R9: The largest compare value, 2^width − 1, gives a one-shot timeout of exactly that many count clocks.
- R10: The running counter value reads back, zero-extended, at address 7. The mode register is at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_tick | input | 1 | Slow count-clock enable, sampled once per system clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for status read-clear) |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Level interrupt: compare flag AND mask |

## Verification
A vector table runs the timer with every divider code, in periodic and one-shot modes, with short and long waits. Each entry records the counter and status at a chosen cycle. The long-wait periodic entries catch wrong wrap points and off-by-one periods. The one-shot entries catch a clock that fails to stop. An entry with an unused divider code confirms that nothing counts. Directed sequences then cover the remaining cases: mask set and clear, read-clear, the disable-over-enable priority, compare-value rewrites while running and while stopped, the slow tick, and the full-width timeout.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  localparam int DW    = 32;
  localparam int AW    = 3;
  localparam int SEL_W = 3;

  typedef enum logic [AW-1:0] {
    A_MODE  = 3'd0,
    A_RC    = 3'd1,
    A_CTRL  = 3'd2,
    A_STAT  = 3'd3,
    A_IEN   = 3'd4,
    A_IDIS  = 3'd5,
    A_IMASK = 3'd6,
    A_CNT   = 3'd7
  } reg_addr_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_DIS   = 1;
  localparam int CTL_TRIG  = 2;
  localparam int ST_CMP    = 0;
  localparam int ST_CLKON  = 1;
  localparam int MODE_STOP = 3;
endpackage

// File: rtl/evt_tmr_presc.sv
module evt_tmr_presc
  import evt_tmr_pkg::*;
#(
  parameter int NUM_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  input  logic             slow_tick,
  output logic             tick
);
  localparam int DIV_W = 2 * NUM_DIV - 1;

  logic [DIV_W-1:0]   div_q, div_d;
  logic [NUM_DIV-1:0] tap;

  // Divider i fires when its low 2i+1 bits are all ones: divide by 2^(2i+1).
  genvar g;
  for (g = 0; g < NUM_DIV; g++) begin : g_tap
    assign tap[g] = &div_q[2*g:0];
  end

  always_comb begin
    div_d = restart ? '0 : div_q + 1'b1;
  end

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (sel == SEL_W'(i)) tick = tap[i];
    end
    if (sel == SEL_W'(NUM_DIV)) tick = slow_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/evt_tmr_core.sv
module evt_tmr_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cmd_en,
  input  logic         cmd_dis,
  input  logic         cmd_trig,
  input  logic         oneshot,
  input  logic [W-1:0] rc,
  output logic [W-1:0] cnt,
  output logic         clk_on,
  output logic         cmp_hit
);
  logic [W-1:0] cnt_q, cnt_d, cnt_inc;
  logic         on_q, on_d;
  logic         step;

  assign step    = on_q && tick && !cmd_trig;
  assign cnt_inc = cnt_q + 1'b1;
  assign cmp_hit = step && (cnt_inc == rc);

  always_comb begin
    cnt_d = cnt_q;
    if (cmd_trig)          cnt_d = '0;
    else if (step)         cnt_d = (cnt_q == rc) ? '0 : cnt_inc;
  end

  always_comb begin
    on_d = on_q;
    if (cmd_dis)                   on_d = 1'b0;
    else if (cmd_en)               on_d = 1'b1;
    else if (cmp_hit && oneshot)   on_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      on_q  <= on_d;
    end
  end

  assign cnt    = cnt_q;
  assign clk_on = on_q;
endmodule

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
  import evt_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             cmp_hit,
  input  logic             clk_on,
  input  logic [W-1:0]     cnt,
  output logic [SEL_W-1:0] sel,
  output logic             oneshot,
  output logic [W-1:0]     rc,
  output logic             cmd_en,
  output logic             cmd_dis,
  output logic             cmd_trig,
  output logic             flag,
  output logic             mask,
  output logic [DW-1:0]    rdata,
  output logic             irq
);
  localparam int MODE_W = SEL_W + 1;

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [W-1:0]      rc_q, rc_d;
  logic              mask_q, mask_d;
  logic              flag_q, flag_d;
  logic              wr_ctrl, rd_stat;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;
  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign rd_stat  = rd_en && (addr == A_STAT);
  assign cmd_en   = wr_ctrl && wdata[CTL_EN];
  assign cmd_dis  = wr_ctrl && wdata[CTL_DIS];
  assign cmd_trig = wr_ctrl && wdata[CTL_TRIG];

  always_comb begin
    mode_d = mode_q;
    rc_d   = rc_q;
    mask_d = mask_q;
    if (wr_en && addr == A_MODE) mode_d = wdata[MODE_W-1:0];
    if (wr_en && addr == A_RC)   rc_d   = wdata[W-1:0];
    if (wr_en && addr == A_IEN  && wdata[0]) mask_d = 1'b1;
    if (wr_en && addr == A_IDIS && wdata[0]) mask_d = 1'b0;
  end

  always_comb begin
    flag_d = flag_q;
    if (rd_stat) flag_d = 1'b0;
    if (cmp_hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rc_q   <= '0;
      mask_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rc_q   <= rc_d;
      mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE:  rdata[MODE_W-1:0] = mode_q;
      A_RC:    rdata = DW'(rc_q);
      A_STAT: begin
        rdata[ST_CMP]   = flag_q;
        rdata[ST_CLKON] = clk_on;
      end
      A_IMASK: rdata[0] = mask_q;
      A_CNT:   rdata = DW'(cnt);
      default: rdata = '0;
    endcase
  end

  assign sel     = mode_q[SEL_W-1:0];
  assign oneshot = mode_q[MODE_STOP];
  assign rc      = rc_q;
  assign flag    = flag_q;
  assign mask    = mask_q;
  assign irq     = flag_q && mask_q;
endmodule

// File: rtl/evt_tmr_chan.sv
module evt_tmr_chan
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic [1:0]       rs_q;
  logic             rst_s;
  logic             tick;
  logic [SEL_W-1:0] sel;
  logic             oneshot;
  logic [CNT_W-1:0] rc, cnt;
  logic             cmd_en, cmd_dis, cmd_trig;
  logic             flag, mask, clk_on, cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  evt_tmr_presc #(.NUM_DIV(NUM_DIV)) u_presc (
    .clk(clk), .rst_n(rst_s), .restart(cmd_trig), .sel(sel),
    .slow_tick(slow_tick), .tick(tick)
  );

  evt_tmr_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_s), .tick(tick), .cmd_en(cmd_en),
    .cmd_dis(cmd_dis), .cmd_trig(cmd_trig), .oneshot(oneshot), .rc(rc),
    .cnt(cnt), .clk_on(clk_on), .cmp_hit(cmp_hit)
  );

  evt_tmr_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cmp_hit(cmp_hit), .clk_on(clk_on), .cnt(cnt),
    .sel(sel), .oneshot(oneshot), .rc(rc), .cmd_en(cmd_en),
    .cmd_dis(cmd_dis), .cmd_trig(cmd_trig), .flag(flag), .mask(mask),
    .rdata(rdata), .irq(irq)
  );
endmodule

// File: rtl/evt_tmr_chk.sv
module evt_tmr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic [2:0]   addr,
  input logic         wd0,
  input logic         cmd_en,
  input logic         cmd_dis,
  input logic         cmd_trig,
  input logic         oneshot,
  input logic         cmp_hit,
  input logic         flag,
  input logic         clk_on,
  input logic         irq,
  input logic [W-1:0] cnt,
  input logic [W-1:0] rc
);
  // R3: a compare always leaves the flag set
  a_r3_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> flag);

  // R3: counter lands on the compare value on a hit
  a_r3_hit_lands_on_rc: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> (cnt == $past(rc)));

  // R4: one-shot compare stops the channel clock
  a_r4_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && oneshot && !cmd_en) |=> !clk_on);

  // R5: disable command wins
  a_r5_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dis |=> !clk_on);

  // R6: status read clears the flag unless a compare coincides
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd5 - 3'd2 && !cmp_hit) |=> !flag);

  // R7: clearing the mask bit silences the interrupt
  a_r7_mask_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5 && wd0) |=> !irq);

  // R8: a stopped counter does not move
  a_r8_stopped_static: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_on && !cmd_trig) |=> $stable(cnt));

  // R8: no compare while stopped
  a_r8_no_hit_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |-> !cmp_hit);
endmodule

bind evt_tmr_chan evt_tmr_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wd0(wdata[0]), .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trig(cmd_trig),
  .oneshot(oneshot), .cmp_hit(cmp_hit), .flag(flag), .clk_on(clk_on),
  .irq(irq), .cnt(cnt), .rc(rc)
);

// File: tb/sim_evt_tmr_chan.sv
module sim_evt_tmr_chan;
  localparam int CW   = 16;
  localparam int MAXV = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_tmr_chan #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {sel, oneshot, rc, wait edges k, counter after edge k, status after edge k+1}
  localparam int VN = 9;
  localparam logic [53:0] VEC [VN] = '{
    {3'd0, 1'b0, 16'd5, 16'd10,  16'd5, 2'd3},
    {3'd0, 1'b0, 16'd5, 16'd12,  16'd0, 2'd3},
    {3'd0, 1'b0, 16'd5, 16'd30,  16'd3, 2'd3},
    {3'd1, 1'b0, 16'd3, 16'd20,  16'd2, 2'd2},
    {3'd1, 1'b1, 16'd3, 16'd40,  16'd3, 2'd1},
    {3'd2, 1'b1, 16'd2, 16'd100, 16'd2, 2'd1},
    {3'd3, 1'b0, 16'd1, 16'd300, 16'd0, 2'd3},
    {3'd0, 1'b1, 16'd1, 16'd1,   16'd0, 2'd1},
    {3'd5, 1'b0, 16'd2, 16'd50,  16'd0, 2'd2}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // All bus tasks start and end just after a falling edge, consuming one rising edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic start(input logic [2:0] sel, input logic one, input logic [15:0] rc);
    logic [31:0] dummy;
    wr(3'd2, 32'h2);
    rd(3'd3, dummy);
    wr(3'd0, {28'd0, one, sel});
    wr(3'd1, {16'd0, rc});
    wr(3'd2, 32'h5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(3'd3, v); chk("R1 status", v, 0);
    rd(3'd6, v); chk("R1 mask", v, 0);
    rd(3'd7, v); chk("R1 counter", v, 0);
    rd(3'd1, v); chk("R1 compare", v, 0);
    rd(3'd0, v); chk("R1 mode", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    wr(3'd4, 32'h1);
    rd(3'd6, v); chk("R7 mask set", v, 1);

    // Table: R2 dividers, R3 periodic, R4 one-shot, R10 readback
    for (int i = 0; i < VN; i++) begin
      logic [53:0] e;
      e = VEC[i];
      start(e[53:51], e[50], e[49:34]);
      repeat (int'(e[33:18])) @(negedge clk);
      rd(3'd7, v);
      chk($sformatf("R2/R3/R4/R10 vec%0d counter", i), v, {16'd0, e[17:2]});
      rd(3'd3, v);
      chk($sformatf("R3/R4/R6 vec%0d status", i), v, {30'd0, e[1:0]});
    end

    // R7 mask clear and R6 read-clear
    start(3'd0, 1'b1, 16'd1);
    repeat (3) @(negedge clk);
    chk("R7 irq on flag and mask", {31'd0, irq}, 1);
    wr(3'd5, 32'hFF);
    chk("R7 irq off after mask clear", {31'd0, irq}, 0);
    rd(3'd6, v); chk("R7 mask cleared", v, 0);
    rd(3'd3, v); chk("R6 flag still set while masked", v, 1);
    rd(3'd3, v); chk("R6 flag cleared by read", v, 0);
    wr(3'd4, 32'h1);
    start(3'd0, 1'b1, 16'd1);
    repeat (3) @(negedge clk);
    chk("R6 irq before read", {31'd0, irq}, 1);
    rd(3'd3, v);
    chk("R6 irq after read", {31'd0, irq}, 0);

    // R5 disable priority and stop
    start(3'd0, 1'b0, 16'd100);
    repeat (10) @(negedge clk);
    wr(3'd2, 32'h3);
    rd(3'd3, v); chk("R5 en+dis leaves clock off", v, 0);
    rd(3'd7, v);
    repeat (10) @(negedge clk);
    rd(3'd7, v2); chk("R5 stopped counter holds", v2, v);
    rd(3'd2, v2); chk("R5 command reads zero", v2, 0);

    // R8 compare written equal to held count while stopped
    wr(3'd1, v);
    repeat (4) @(negedge clk);
    rd(3'd3, v2); chk("R8 no compare while stopped", v2, 0);

    // R8 compare change while running
    start(3'd0, 1'b0, 16'd100);
    repeat (6) @(negedge clk);
    wr(3'd1, 32'd5);
    repeat (4) @(negedge clk);
    rd(3'd7, v); chk("R8 counter at new compare", v, 5);
    rd(3'd3, v); chk("R8 new compare raises flag", v, 3);

    // R2 slow source
    start(3'd4, 1'b1, 16'd3);
    repeat (20) @(negedge clk);
    rd(3'd7, v); chk("R2 slow idle no count", v, 0);
    slow_tick = 1'b1;
    repeat (3) @(negedge clk);
    slow_tick = 1'b0;
    rd(3'd7, v); chk("R2 slow counts ticks", v, 3);
    rd(3'd3, v); chk("R4 slow one-shot stopped", v, 1);

    // R9 full-width timeout, one count per cycle
    slow_tick = 1'b1;
    start(3'd4, 1'b1, 16'(MAXV));
    repeat (MAXV - 1) @(negedge clk);
    rd(3'd7, v); chk("R9 one short of max", v, MAXV - 1);
    rd(3'd3, v); chk("R9 timeout at max", v, 1);
    rd(3'd7, v); chk("R9 holds at max", v, MAXV);
    slow_tick = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule